// File: doc/BRIEF.md
# Coefficient Safeload Staging Buffer

This block lets a host replace a small group of filter coefficients while the signal-processing core keeps reading its coefficient memory. The host first fills up to five staging slots. Each slot holds an 8-bit memory address and a 22-bit coefficient word in 2.20 two's complement form. A single trigger then arms a commit. The block copies the filled slots into the coefficient memory only in cycles where the core reports that the memory is idle. Because all five coefficients of a biquad section fit in one commit, they change together within one audio frame.

The write port drives only the 256-entry coefficient memory. It has no path to program storage or control registers. While a commit is pending, the staging slots are locked against host writes, and an error flag records any attempt to write them. If the idle window closes part way through a commit, the block finishes the remaining slots in a later idle window.

Top module: `coef_stage_buf`

## Requirements
- R1: After reset, `pending`, `stage_err` and `ram_we` are 0 and no staging slot is marked filled.
- R2: A host write (`host_we`=1) with `host_sel` in 0..4 while `pending`=0 stores `host_addr`/`host_data` in that slot and marks it filled. A write with `host_sel` of 5 or more is ignored.
- R3: `host_go` with `pending`=0 and at least one filled slot raises `pending` on the next cycle. `host_go` with no filled slot has no effect.
- R4: `ram_we` is 1 only in cycles where `ram_busy` is 0. While `pending`=1 and `ram_busy`=0, exactly one slot is written in each cycle.
- R5: Only filled slots are written, each exactly once, in ascending slot-index order, whatever order the host filled them in. A slot is no longer filled once it has been written.
- R6: If `ram_busy` rises before all slots are written, writing stops and `pending` stays 1. Writing resumes with the next unwritten slot when `ram_busy` falls. `pending` drops in the cycle after the final write.
- R7: Host writes to any slot while `pending`=1 change no staged content and set `stage_err`. `stage_err` stays set until the next accepted trigger clears it.
- R8: When all five slots are filled and the memory stays idle, the commit finishes in five consecutive cycles.
- R9: `host_go` while `pending`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for a staging slot |
| host_sel | input | 3 | Staging slot index |
| host_addr | input | 8 | Target coefficient address for the slot |
| host_data | input | 22 | Coefficient word (2.20 two's complement) |
| host_go | input | 1 | Trigger that arms the commit |
| ram_busy | input | 1 | Core is reading the coefficient memory this cycle |
| ram_we | output | 1 | Coefficient memory write enable |
| ram_waddr | output | 8 | Coefficient memory write address |
| ram_wdata | output | 22 | Coefficient memory write data |
| pending | output | 1 | Commit armed and not yet complete |
| stage_err | output | 1 | Sticky flag: host wrote while a commit was pending |

## Verification
The commit path is exercised with four fill patterns:
- A single slot.
- Three slots filled out of index order while the memory is busy. This separates index-ordered draining from fill-ordered draining, and shows that no write leaks while `ram_busy` is high.
- All five slots with an idle memory, which checks the five-cycle back-to-back commit.
- All five slots with a busy interval in the middle of the commit, which checks the stall and the resume.

A locked-buffer scenario overwrites a staged slot during a pending commit. It then checks that the original word reaches the memory, that the error flag sets and later clears, and that a retrigger during the commit and a trigger with nothing staged both do nothing.

// File: rtl/coef_stage_pkg.sv
package coef_stage_pkg;
  parameter int CS_AW    = 8;
  parameter int CS_DW    = 22;
  parameter int CS_SLOTS = 5;

  typedef struct packed {
    logic [CS_AW-1:0] addr;
    logic [CS_DW-1:0] data;
  } cs_pair_t;
endpackage

// File: rtl/coef_stage_slots.sv
module coef_stage_slots
  import coef_stage_pkg::*;
#(
  parameter int NSLOTS = CS_SLOTS,
  localparam int SW    = $clog2(NSLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SW-1:0]         wr_sel,
  input  cs_pair_t              wr_pair,
  input  logic                  clr_en,
  input  logic [NSLOTS-1:0]     clr_mask,
  output logic [NSLOTS-1:0]     valid_q,
  output cs_pair_t [NSLOTS-1:0] slot_q
);
  logic [NSLOTS-1:0] wr_hit;
  logic [NSLOTS-1:0] valid_d;

  for (genvar gi = 0; gi < NSLOTS; gi++) begin : g_slot
    assign wr_hit[gi] = wr_en && (wr_sel == SW'(gi));

    always_comb begin
      valid_d[gi] = valid_q[gi];
      if (wr_hit[gi])
        valid_d[gi] = 1'b1;
      else if (clr_en && clr_mask[gi])
        valid_d[gi] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wr_hit[gi])
        slot_q[gi] <= wr_pair;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else
      valid_q <= valid_d;
  end

  // R5: every commit cycle retires exactly one filled slot
  a_r5_one_retired: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> ($countones(valid_q) == $countones($past(valid_q)) - 1));
endmodule

// File: rtl/coef_stage_pick.sv
module coef_stage_pick #(
  parameter int NSLOTS = 5,
  localparam int IW    = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOTS-1:0] valid,
  output logic [NSLOTS-1:0] grant,
  output logic [IW-1:0]     idx,
  output logic              any
);
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    idx   = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (valid[i] && !seen) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        seen     = 1'b1;
      end
    end
    any = seen;
  end

  // R5: a single slot is chosen, and only a filled one
  a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~valid) == '0));
endmodule

// File: rtl/coef_stage_ctrl.sv
module coef_stage_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic host_go,
  input  logic host_we,
  input  logic any_valid,
  input  logic commit,
  input  logic commit_last,
  output logic pending_q,
  output logic err_q
);
  logic pending_d;
  logic err_d;
  logic arm;

  assign arm = host_go && !pending_q && any_valid;

  always_comb begin
    pending_d = pending_q;
    if (arm)
      pending_d = 1'b1;
    else if (pending_q && commit && commit_last)
      pending_d = 1'b0;
  end

  always_comb begin
    err_d = err_q;
    if (arm)
      err_d = 1'b0;
    else if (pending_q && host_we)
      err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      err_q     <= err_d;
    end
  end

  // R6: a commit stays armed until its last slot is written
  a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !(commit && commit_last)) |=> pending_q);
  // R7: a locked write leaves the error flag set
  a_r7_err_on_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && host_we) |=> err_q);
endmodule

// File: rtl/coef_stage_buf.sv
module coef_stage_buf
  import coef_stage_pkg::*;
#(
  parameter int NSLOTS = CS_SLOTS,
  localparam int SW    = $clog2(NSLOTS + 1),
  localparam int IW    = $clog2(NSLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [SW-1:0]    host_sel,
  input  logic [CS_AW-1:0] host_addr,
  input  logic [CS_DW-1:0] host_data,
  input  logic             host_go,
  input  logic             ram_busy,
  output logic             ram_we,
  output logic [CS_AW-1:0] ram_waddr,
  output logic [CS_DW-1:0] ram_wdata,
  output logic             pending,
  output logic             stage_err
);
  logic [NSLOTS-1:0]     valid_q;
  cs_pair_t [NSLOTS-1:0] slot_q;
  logic [NSLOTS-1:0]     grant;
  logic [IW-1:0]         idx;
  logic                  any_valid;
  logic                  wr_accept;
  logic                  commit;
  logic                  commit_last;
  cs_pair_t              wr_pair;

  assign wr_pair.addr = host_addr;
  assign wr_pair.data = host_data;
  assign wr_accept    = host_we && !pending && (host_sel < SW'(NSLOTS));
  assign commit       = pending && !ram_busy && any_valid;
  assign commit_last  = (valid_q == grant);

  coef_stage_slots #(.NSLOTS(NSLOTS)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_accept),
    .wr_sel   (host_sel),
    .wr_pair  (wr_pair),
    .clr_en   (commit),
    .clr_mask (grant),
    .valid_q  (valid_q),
    .slot_q   (slot_q)
  );

  coef_stage_pick #(.NSLOTS(NSLOTS)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid_q),
    .grant (grant),
    .idx   (idx),
    .any   (any_valid)
  );

  coef_stage_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_go     (host_go),
    .host_we     (host_we),
    .any_valid   (any_valid),
    .commit      (commit),
    .commit_last (commit_last),
    .pending_q   (pending),
    .err_q       (stage_err)
  );

  assign ram_we    = commit;
  assign ram_waddr = slot_q[idx].addr;
  assign ram_wdata = slot_q[idx].data;

  // R4: the memory is written only in idle cycles
  a_r4_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !ram_busy);
  // R4: an armed commit with an idle memory always writes
  a_r4_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ram_busy) |-> ram_we);
  // R3: an accepted trigger arms the commit
  a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (host_go && !pending && (valid_q != '0)) |=> pending);
endmodule

// File: tb/coef_stage_buf_bench.sv
module coef_stage_buf_bench;
  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic [2:0]  host_sel;
  logic [7:0]  host_addr;
  logic [21:0] host_data;
  logic        host_go;
  logic        ram_busy;
  logic        ram_we;
  logic [7:0]  ram_waddr;
  logic [21:0] ram_wdata;
  logic        pending;
  logic        stage_err;

  int n_cmp;
  int n_bad;

  coef_stage_buf u_coef_stage_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_sel  (host_sel),
    .host_addr (host_addr),
    .host_data (host_data),
    .host_go   (host_go),
    .ram_busy  (ram_busy),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .pending   (pending),
    .stage_err (stage_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr_slot(input logic [2:0] s, input logic [7:0] a, input logic [21:0] d);
    host_we = 1'b1; host_sel = s; host_addr = a; host_data = d;
    tick();
    host_we = 1'b0;
  endtask

  task automatic go();
    host_go = 1'b1;
    tick();
    host_go = 1'b0;
  endtask

  task automatic exp_write(input string req, input logic [7:0] a, input logic [21:0] d);
    chk({req, " we"}, 32'(ram_we), 32'd1);
    chk({req, " addr"}, 32'(ram_waddr), 32'(a));
    chk({req, " data"}, 32'(ram_wdata), 32'(d));
    tick();
  endtask

  function automatic logic [21:0] pat(input int k);
    return 22'(32'h15A5A + k * 32'h1111);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; host_we = 1'b0; host_sel = '0; host_addr = '0;
    host_data = '0; host_go = 1'b0; ram_busy = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 pending", 32'(pending), 32'd0);
    chk("R1 err", 32'(stage_err), 32'd0);
    chk("R1 we", 32'(ram_we), 32'd0);
    go();
    chk("R1 no slot filled", 32'(pending), 32'd0);
  endtask

  task automatic t_bad_sel();
    wr_slot(3'd5, 8'h33, 22'h1);
    wr_slot(3'd7, 8'h34, 22'h2);
    go();
    chk("R2 out-of-range slot ignored", 32'(pending), 32'd0);
    chk("R2 no write", 32'(ram_we), 32'd0);
  endtask

  task automatic t_single();
    ram_busy = 1'b0;
    wr_slot(3'd2, 8'h10, 22'h100000);
    go();
    chk("R3 armed", 32'(pending), 32'd1);
    exp_write("R2 single slot", 8'h10, 22'h100000);
    chk("R6 pending drops", 32'(pending), 32'd0);
    chk("R5 written once", 32'(ram_we), 32'd0);
  endtask

  task automatic t_order();
    ram_busy = 1'b1;
    wr_slot(3'd4, 8'hC4, pat(4));
    wr_slot(3'd0, 8'hC0, pat(0));
    wr_slot(3'd3, 8'hC3, pat(3));
    go();
    chk("R3 armed", 32'(pending), 32'd1);
    tick();
    chk("R4 no write while busy", 32'(ram_we), 32'd0);
    ram_busy = 1'b0;
    #1;
    exp_write("R5 order first", 8'hC0, pat(0));
    exp_write("R5 order second", 8'hC3, pat(3));
    exp_write("R5 order third", 8'hC4, pat(4));
    chk("R5 done", 32'(ram_we), 32'd0);
    chk("R6 pending drops", 32'(pending), 32'd0);
  endtask

  task automatic t_full();
    ram_busy = 1'b0;
    for (int i = 0; i < 5; i++) wr_slot(3'(i), 8'(8'hF0 + i), pat(10 + i));
    go();
    for (int i = 0; i < 5; i++) exp_write("R8 back-to-back", 8'(8'hF0 + i), pat(10 + i));
    chk("R8 complete after five", 32'(pending), 32'd0);
  endtask

  task automatic t_interrupt();
    ram_busy = 1'b0;
    for (int i = 0; i < 5; i++) wr_slot(3'(i), 8'(8'h20 + i), pat(20 + i));
    go();
    exp_write("R6 before stall", 8'h20, pat(20));
    exp_write("R6 before stall", 8'h21, pat(21));
    ram_busy = 1'b1;
    #1;
    for (int k = 0; k < 3; k++) begin
      chk("R4 stalled", 32'(ram_we), 32'd0);
      chk("R6 pending held", 32'(pending), 32'd1);
      tick();
    end
    ram_busy = 1'b0;
    #1;
    exp_write("R6 resume", 8'h22, pat(22));
    exp_write("R6 resume", 8'h23, pat(23));
    exp_write("R6 resume", 8'h24, pat(24));
    chk("R6 pending drops", 32'(pending), 32'd0);
  endtask

  task automatic t_locked();
    ram_busy = 1'b1;
    wr_slot(3'd1, 8'h41, 22'h0AAAAA);
    go();
    chk("R7 err clear", 32'(stage_err), 32'd0);
    wr_slot(3'd1, 8'h99, 22'h355555);
    wr_slot(3'd2, 8'h98, 22'h012345);
    chk("R7 err set", 32'(stage_err), 32'd1);
    go();
    chk("R9 retrigger harmless", 32'(pending), 32'd1);
    ram_busy = 1'b0;
    #1;
    exp_write("R7 original kept", 8'h41, 22'h0AAAAA);
    chk("R7 no extra slot", 32'(ram_we), 32'd0);
    chk("R7 pending drops", 32'(pending), 32'd0);
    chk("R7 err sticky", 32'(stage_err), 32'd1);
    go();
    chk("R3 empty trigger ignored", 32'(pending), 32'd0);
    chk("R3 empty trigger err", 32'(stage_err), 32'd1);
    ram_busy = 1'b1;
    wr_slot(3'd0, 8'h50, 22'h3FFFFF);
    go();
    chk("R7 err cleared by trigger", 32'(stage_err), 32'd0);
    ram_busy = 1'b0;
    #1;
    exp_write("R7 after clear", 8'h50, 22'h3FFFFF);
  endtask

  logic done;

  initial begin
    done = 1'b0;
    n_cmp = 0;
    n_bad = 0;
    t_reset();
    t_bad_sel();
    t_single();
    t_order();
    t_full();
    t_interrupt();
    t_locked();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule